// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel that sits beside an 8-bit timer/counter. On every timer clock enable it checks the counter value against its active compare register. When the two are equal it raises a sticky match flag, which serves as an interrupt request. It also updates a waveform pin with a set, clear or toggle action chosen by a 2-bit output mode.

How the compare register is loaded depends on the waveform mode. In the two non-PWM modes, a CPU write reaches the active register at once. In the two PWM modes the write lands in a shadow buffer. The active register is then reloaded from that buffer at the top or at the bottom of the count, depending on the mode.

The CPU can also force a compare action onto the pin in the non-PWM modes. A forced compare leaves the flag alone. When the CPU writes the counter, it reports that write to this block through a strobe. That strobe blocks the match on the next timer clock, however long that clock takes to arrive.

Top module: `ocu_channel`

## Requirements
- R1: When `tmr_tick` is high, `tmr_count` equals `cmp_active` and no block is pending, `match_flag` is 1 one clock after that edge.
- R2: While `tmr_tick` is low, equality of `tmr_count` and `cmp_active` never sets `match_flag`.
- R3: In waveform modes 00 (normal) and 01 (CTC), a CPU compare write (`cpu_cmp_we`) appears on `cmp_active` one clock later.
- R4: In waveform modes 10 (PWM, reload at top) and 11 (PWM, reload at bottom), `cmp_active` keeps its value after a CPU write. It takes the last written value only on a clock where `tmr_tick` is high together with `tmr_top` (mode 10) or `tmr_bottom` (mode 11).
- R5: On a match, `out_mode` sets the new pin value as follows: 00 leaves `wave_pin` unchanged, 01 inverts it, 10 drives it to 0, and 11 drives it to 1.
- R6: In modes 00 and 01, a `cpu_force` pulse applies the `out_mode` action to `wave_pin` one clock later and leaves `match_flag` unchanged.
- R7: In modes 10 and 11, `cpu_force` has no effect on `wave_pin`.
- R8: A `cpu_cnt_we` pulse suppresses the match at the next clock with `tmr_tick` high, even after any number of clocks without a tick. The tick after that one matches normally.
- R9: A `cpu_flag_clr` pulse clears `match_flag`, unless a match occurs in the same clock, in which case the flag stays 1.
- R10: During reset, `match_flag`, `wave_pin` and `cmp_active` are all 0.
- R11: A force and a match in the same clock apply the `out_mode` action to `wave_pin` only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cmp_we | input | 1 | CPU write strobe for the compare value |
| cpu_cmp_wdata | input | 8 | Compare value to write |
| cpu_cnt_we | input | 1 | Signals that the CPU wrote the counter (blocks the next match) |
| cpu_force | input | 1 | Force-compare strobe |
| cpu_flag_clr | input | 1 | Clears the match flag (a written one) |
| tmr_tick | input | 1 | Timer clock enable |
| tmr_count | input | 8 | Current counter value |
| tmr_top | input | 1 | Counter is at the top of its sequence |
| tmr_bottom | input | 1 | Counter is at the bottom of its sequence |
| wave_mode | input | 2 | Waveform mode: 00 normal, 01 CTC, 10 PWM reload at top, 11 PWM reload at bottom |
| out_mode | input | 2 | Pin action: 00 hold, 01 toggle, 10 clear, 11 set |
| match_flag | output | 1 | Sticky compare-match interrupt request |
| wave_pin | output | 1 | Waveform output pin |
| cmp_active | output | 8 | Compare value currently in use |

## Verification
Two pairs of events can land on the same clock and both need a defined result. The first pair is a CPU flag clear and a real match: the bench raises `cpu_flag_clr` on the same clock as a matching tick and expects the flag to stay set. The second pair is a force strobe and a matching tick in toggle mode: the bench expects the pin to invert once, not twice. The bench follows each pin action on a model of its own. It also checks that the blocked tick after a counter write leaves both the flag and the pin untouched.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

  typedef enum logic [1:0] {
    WM_NORMAL  = 2'b00,
    WM_CTC     = 2'b01,
    WM_PWM_TOP = 2'b10,
    WM_PWM_BOT = 2'b11
  } wave_mode_e;

  typedef enum logic [1:0] {
    OM_HOLD   = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLEAR  = 2'b10,
    OM_SET    = 2'b11
  } out_mode_e;

  // PWM modes share the upper mode bit
  function automatic logic mode_is_pwm(input logic [1:0] wm);
    return wm[1];
  endfunction

  // Reload point for the shadow compare buffer
  function automatic logic reload_point(input logic [1:0] wm,
                                        input logic top,
                                        input logic bottom);
    logic r;
    case (wm)
      WM_PWM_TOP: r = top;
      WM_PWM_BOT: r = bottom;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

  // New pin level after one compare action
  function automatic logic pin_after(input logic [1:0] om, input logic pin);
    logic r;
    case (om)
      OM_TOGGLE: r = ~pin;
      OM_CLEAR:  r = 1'b0;
      OM_SET:    r = 1'b1;
      default:   r = pin;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ocu_cmp_store.sv
module ocu_cmp_store #(
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMP_W-1:0] wr_data,
  input  logic             pwm_mode,
  input  logic             reload_evt,
  output logic [CMP_W-1:0] active
);
  logic [CMP_W-1:0] shadow_q;
  logic [CMP_W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_en) shadow_q <= wr_data;
      if (pwm_mode) begin
        if (reload_evt) active_q <= shadow_q;
      end else if (wr_en) begin
        active_q <= wr_data;
      end
    end
  end

  assign active = active_q;
endmodule

// File: rtl/ocu_match_det.sv
module ocu_match_det #(
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CMP_W-1:0] count,
  input  logic [CMP_W-1:0] active,
  input  logic             cnt_wr,
  output logic             match_evt,
  output logic             block_pending
);
  logic block_q;
  logic equal;

  assign equal = (count == active);

  // A counter write arms a one-shot block consumed by the next tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      block_q <= 1'b0;
    else if (cnt_wr) block_q <= 1'b1;
    else if (tick)   block_q <= 1'b0;
  end

  assign match_evt     = tick & equal & ~block_q;
  assign block_pending = block_q;
endmodule

// File: rtl/ocu_wave_out.sv
module ocu_wave_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match_evt,
  input  logic       force_evt,
  input  logic [1:0] out_mode,
  output logic       pin
);
  import ocu_pkg::*;
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pin_q <= 1'b0;
    else if (match_evt || force_evt) pin_q <= pin_after(out_mode, pin_q);
  end

  assign pin = pin_q;
endmodule

// File: rtl/ocu_irq_flag.sv
module ocu_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  assign flag = flag_q;
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel #(
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_cmp_we,
  input  logic [CMP_W-1:0] cpu_cmp_wdata,
  input  logic             cpu_cnt_we,
  input  logic             cpu_force,
  input  logic             cpu_flag_clr,
  input  logic             tmr_tick,
  input  logic [CMP_W-1:0] tmr_count,
  input  logic             tmr_top,
  input  logic             tmr_bottom,
  input  logic [1:0]       wave_mode,
  input  logic [1:0]       out_mode,
  output logic             match_flag,
  output logic             wave_pin,
  output logic [CMP_W-1:0] cmp_active
);
  import ocu_pkg::*;

  logic pwm_mode;
  logic reload_evt;
  logic match_evt;
  logic force_evt;
  logic block_pending;

  assign pwm_mode   = mode_is_pwm(wave_mode);
  assign reload_evt = tmr_tick & reload_point(wave_mode, tmr_top, tmr_bottom);
  assign force_evt  = cpu_force & ~pwm_mode;

  ocu_cmp_store #(.CMP_W(CMP_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cpu_cmp_we),
    .wr_data    (cpu_cmp_wdata),
    .pwm_mode   (pwm_mode),
    .reload_evt (reload_evt),
    .active     (cmp_active)
  );

  ocu_match_det #(.CMP_W(CMP_W)) u_match (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tmr_tick),
    .count         (tmr_count),
    .active        (cmp_active),
    .cnt_wr        (cpu_cnt_we),
    .match_evt     (match_evt),
    .block_pending (block_pending)
  );

  ocu_wave_out u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_evt (match_evt),
    .force_evt (force_evt),
    .out_mode  (out_mode),
    .pin       (wave_pin)
  );

  ocu_irq_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (match_evt),
    .clr_req (cpu_flag_clr),
    .flag    (match_flag)
  );
endmodule

// File: rtl/ocu_checker.sv
module ocu_checker #(
  parameter int CMP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_cmp_we,
  input logic [CMP_W-1:0] cpu_cmp_wdata,
  input logic             cpu_force,
  input logic             cpu_flag_clr,
  input logic             tmr_tick,
  input logic [1:0]       out_mode,
  input logic             match_flag,
  input logic             wave_pin,
  input logic [CMP_W-1:0] cmp_active,
  input logic             pwm_mode,
  input logic             reload_evt,
  input logic             match_evt,
  input logic             force_evt,
  input logic             block_pending
);
  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> match_flag); // R1
  AST_NO_TICK_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_tick && !match_flag) |=> !match_flag); // R2
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_cmp_we && !pwm_mode) |=> (cmp_active == $past(cpu_cmp_wdata))); // R3
  AST_PWM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !reload_evt) |=> $stable(cmp_active)); // R4
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ((match_evt || force_evt) && out_mode == 2'b00) |=> $stable(wave_pin)); // R5
  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (force_evt && !match_evt && !match_flag) |=> !match_flag); // R6
  AST_PWM_FORCE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_force && pwm_mode && !match_evt) |=> $stable(wave_pin)); // R7
  AST_BLOCKED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (block_pending && tmr_tick && !match_flag) |=> !match_flag); // R8
  AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_flag_clr && !match_evt) |=> !match_flag); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (!match_flag && !wave_pin && cmp_active == '0)); // R10
endmodule

bind ocu_channel ocu_checker #(.CMP_W(CMP_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_cmp_we    (cpu_cmp_we),
  .cpu_cmp_wdata (cpu_cmp_wdata),
  .cpu_force     (cpu_force),
  .cpu_flag_clr  (cpu_flag_clr),
  .tmr_tick      (tmr_tick),
  .out_mode      (out_mode),
  .match_flag    (match_flag),
  .wave_pin      (wave_pin),
  .cmp_active    (cmp_active),
  .pwm_mode      (pwm_mode),
  .reload_evt    (reload_evt),
  .match_evt     (match_evt),
  .force_evt     (force_evt),
  .block_pending (block_pending)
);

// File: tb/ocu_channel_bench.sv
module ocu_channel_bench;
  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_cmp_we = 0, cpu_cnt_we = 0, cpu_force = 0, cpu_flag_clr = 0;
  logic [7:0] cpu_cmp_wdata = '0, tmr_count = '0;
  logic       tmr_tick = 0, tmr_top = 0, tmr_bottom = 0;
  logic [1:0] wave_mode = 2'b00, out_mode = 2'b00;
  logic       match_flag, wave_pin;
  logic [7:0] cmp_active;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;
  logic exp_pin = 1'b0;

  // {out_mode, expected pin after a match}, walked in order from pin = 0
  localparam logic [2:0] VECS [8] = '{3'b111, 3'b010, 3'b011, 3'b100,
                                      3'b000, 3'b111, 3'b001, 3'b100};

  always #(CLK_PER/2) clk = ~clk;

  ocu_channel u_ocu_channel (
    .clk(clk), .rst_n(rst_n), .cpu_cmp_we(cpu_cmp_we), .cpu_cmp_wdata(cpu_cmp_wdata),
    .cpu_cnt_we(cpu_cnt_we), .cpu_force(cpu_force), .cpu_flag_clr(cpu_flag_clr),
    .tmr_tick(tmr_tick), .tmr_count(tmr_count), .tmr_top(tmr_top),
    .tmr_bottom(tmr_bottom), .wave_mode(wave_mode), .out_mode(out_mode),
    .match_flag(match_flag), .wave_pin(wave_pin), .cmp_active(cmp_active)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_cmp(input logic [7:0] v);
    cpu_cmp_wdata = v; cpu_cmp_we = 1; cyc(); cpu_cmp_we = 0;
  endtask

  task automatic clear_flag();
    cpu_flag_clr = 1; cyc(); cpu_flag_clr = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cyc(); cyc();
    chk("R10 flag in reset", {7'd0, match_flag}, 8'd0);
    chk("R10 pin in reset", {7'd0, wave_pin}, 8'd0);
    chk("R10 active in reset", cmp_active, 8'h00);
    rst_n = 1; cyc();

    // R3 direct write in normal mode
    wave_mode = 2'b00;
    write_cmp(8'h55);
    chk("R3 direct write", cmp_active, 8'h55);
    write_cmp(8'h40);
    chk("R3 second write", cmp_active, 8'h40);

    // R2 equality without tick
    tmr_count = 8'h40;
    cyc(); cyc(); cyc();
    chk("R2 no tick no flag", {7'd0, match_flag}, 8'd0);

    // R1 / R5 / R9 table of pin actions
    foreach (VECS[i]) begin
      out_mode = VECS[i][2:1];
      tmr_tick = 1; cyc(); tmr_tick = 0;
      chk("R1 flag on match", {7'd0, match_flag}, 8'd1);
      chk("R5 pin action", {7'd0, wave_pin}, {7'd0, VECS[i][0]});
      clear_flag();
      chk("R9 flag cleared", {7'd0, match_flag}, 8'd0);
    end
    exp_pin = 1'b0;

    // R6 force in CTC mode, no match
    wave_mode = 2'b01; out_mode = 2'b01; tmr_count = 8'h10;
    cpu_force = 1; cyc(); cpu_force = 0;
    exp_pin = ~exp_pin;
    chk("R6 force toggles pin", {7'd0, wave_pin}, {7'd0, exp_pin});
    chk("R6 force leaves flag", {7'd0, match_flag}, 8'd0);

    // R7 force ignored in PWM mode
    wave_mode = 2'b10;
    cpu_force = 1; cyc(); cpu_force = 0;
    chk("R7 pwm force ignored", {7'd0, wave_pin}, {7'd0, exp_pin});

    // R8 counter write blocks next tick even after idle clocks
    wave_mode = 2'b00; tmr_count = 8'h40; out_mode = 2'b01;
    cpu_cnt_we = 1; cyc(); cpu_cnt_we = 0;
    cyc(); cyc(); cyc();
    tmr_tick = 1; cyc(); tmr_tick = 0;
    chk("R8 blocked flag", {7'd0, match_flag}, 8'd0);
    chk("R8 blocked pin", {7'd0, wave_pin}, {7'd0, exp_pin});
    tmr_tick = 1; cyc(); tmr_tick = 0;
    exp_pin = ~exp_pin;
    chk("R8 following tick matches", {7'd0, match_flag}, 8'd1);
    chk("R8 following tick pin", {7'd0, wave_pin}, {7'd0, exp_pin});

    // R9 clear and match in the same clock
    out_mode = 2'b00;
    cpu_flag_clr = 1; tmr_tick = 1; cyc(); cpu_flag_clr = 0; tmr_tick = 0;
    chk("R9 match beats clear", {7'd0, match_flag}, 8'd1);
    clear_flag();
    chk("R9 clear alone", {7'd0, match_flag}, 8'd0);

    // R11 force and match together toggle once
    out_mode = 2'b01;
    cpu_force = 1; tmr_tick = 1; cyc(); cpu_force = 0; tmr_tick = 0;
    exp_pin = ~exp_pin;
    chk("R11 single toggle", {7'd0, wave_pin}, {7'd0, exp_pin});
    clear_flag();

    // R4 PWM shadow reload
    out_mode = 2'b00; tmr_count = 8'h00;
    wave_mode = 2'b10;
    write_cmp(8'h77);
    chk("R4 pwm write held", cmp_active, 8'h40);
    tmr_bottom = 1; tmr_tick = 1; cyc(); tmr_bottom = 0; tmr_tick = 0;
    chk("R4 bottom ignored in top mode", cmp_active, 8'h40);
    tmr_top = 1; cyc(); tmr_top = 0;
    chk("R4 top without tick", cmp_active, 8'h40);
    tmr_top = 1; tmr_tick = 1; cyc(); tmr_top = 0; tmr_tick = 0;
    chk("R4 reload at top", cmp_active, 8'h77);
    wave_mode = 2'b11;
    write_cmp(8'h22);
    tmr_top = 1; tmr_tick = 1; cyc(); tmr_top = 0; tmr_tick = 0;
    chk("R4 top ignored in bottom mode", cmp_active, 8'h77);
    tmr_bottom = 1; tmr_tick = 1; cyc(); tmr_bottom = 0; tmr_tick = 0;
    chk("R4 reload at bottom", cmp_active, 8'h22);

    done = 1;
    summary();
    $finish;
  end
endmodule